// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialization

This block keeps an asynchronous page-mode DRAM refreshed and brings it out of power-up. After reset it owns the memory control lines. It first waits a programmable quiet period. It then runs a fixed number of warm-up refresh cycles and only after that raises a ready flag. Until the flag rises, the access controller must leave the array alone.

Once ready, an interval timer adds one owed refresh to a small saturating counter each period. While anything is owed, the block raises a bus request. When the access controller grants the bus, the block runs all owed cycles back to back and then withdraws the request.

Each refresh cycle is either a CAS-before-RAS cycle, where the DRAM uses its own row counter, or a RAS-only cycle. In a RAS-only cycle the block puts its own row number on the address lines. The refresh type is chosen by an input that is sampled at the start of every cycle. All timing is expressed in clock cycles through parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, and for PAUSE_CYC clocks after it is released, ras_n, cas_n and we_n stay high, bus_req is 1 and init_done is 0. No strobe falls in that window.
- R2: After the pause, WARMUP_CNT refresh cycles run without waiting for bus_gnt. init_done rises one clock after the last of them completes and stays high until reset.
- R3: Once init_done is high, one refresh becomes owed every INTERVAL_CYC clocks. bus_req goes to 1 in the clock after the interval completes, and is 0 while nothing is owed and no cycle is running.
- R4: In a CAS-before-RAS cycle (mode_ras_only = 0), cas_n falls CSR_CYC clocks before ras_n falls and rises CHR_CYC clocks after ras_n falls. addr_en stays 0 throughout.
- R5: we_n is high at every falling edge of ras_n and during reset.
- R6: Every ras_n low pulse lasts exactly RAS_LOW_CYC clocks. Before each ras_n fall, ras_n has been high for at least PRE_CYC clocks. cas_n never falls while ras_n is low.
- R7: In a RAS-only cycle (mode_ras_only = 1), cas_n stays high. addr_en is 1 when ras_n falls, and row_addr carries the internal row number at that moment.
- R8: The row number is 0 after reset. It increases by one after each completed RAS-only cycle, is unchanged by CAS-before-RAS cycles, and wraps from 2^ROW_W-1 to 0.
- R9: Refreshes owed while bus_gnt is withheld accumulate up to 2^PEND_W-1, and further intervals are lost. On grant they run back to back, one new cycle every CSR_CYC+RAS_LOW_CYC+PRE_CYC+1 clocks. bus_req drops in the clock after the last cycle's precharge ends.
- R10: After init_done, no ras_n fall occurs while bus_gnt is 0, and ras_n and cas_n are high whenever bus_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ras_only | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| bus_gnt | input | 1 | Access controller hands the memory lines to this block |
| bus_req | output | 1 | This block needs the memory lines |
| init_done | output | 1 | Power-up sequence complete; normal accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr_en | output | 1 | row_addr is to be driven onto the DRAM address lines |
| row_addr | output | ROW_W | Row number for RAS-only refresh |

## Verification
The assertions assume that the access controller keeps bus_gnt high from the moment it grants until bus_req has fallen. They also assume it never withdraws the grant in the middle of a refresh, and that mode_ras_only changes only while no cycle is running. The stimulus follows these rules. It raises the grant only after bus_req is seen high and drops it only in the clock where bus_req is seen low. It changes the mode only between bursts. Bursts are lined up to the interval boundary, so the number owed, and hence the burst length and duration, is exact.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_LOW_A,
    SQ_LOW_B,
    SQ_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_WARM,
    PH_RUN
  } init_phase_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL_CYC = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int CW = $clog2(INTERVAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rfsh_owed_ctr.sv
module rfsh_owed_ctr #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic owed_any
);

  localparam logic [PEND_W-1:0] FULL = '1;

  logic [PEND_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc, dec})
      2'b10: if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
      2'b01: if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  assign owed_any = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rfsh_cycle_seq.sv
module rfsh_cycle_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CSR_CYC     = 1,
  parameter int CHR_CYC     = 1,
  parameter int RAS_LOW_CYC = 3,
  parameter int PRE_CYC     = 2,
  parameter int ROW_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ras_only,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             addr_en,
  output logic             idle,
  output logic             done,
  output logic [ROW_W-1:0] row
);

  localparam int PH_MAX = max_of4(CSR_CYC, CHR_CYC, RAS_LOW_CYC - CHR_CYC, PRE_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] LEAD_LD = PH_W'(CSR_CYC - 1);
  localparam logic [PH_W-1:0] LOWA_LD = PH_W'(CHR_CYC - 1);
  localparam logic [PH_W-1:0] LOWB_LD = PH_W'(RAS_LOW_CYC - CHR_CYC - 1);
  localparam logic [PH_W-1:0] PRE_LD  = PH_W'(PRE_CYC - 1);

  seq_state_e       st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             mode_q, mode_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             ras_n_q, cas_n_q, addr_en_q;
  logic             ras_n_d, cas_n_d, addr_en_d;
  logic             ph_last;

  assign ph_last = (ph_q == '0);

  // next-state logic
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_last ? ph_q : ph_q - 1'b1;
    mode_d = mode_q;
    done   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        ph_d = ph_q;
        if (start) begin
          st_d   = SQ_LEAD;
          ph_d   = LEAD_LD;
          mode_d = ras_only;
        end
      end
      SQ_LEAD: if (ph_last) begin
        st_d = SQ_LOW_A;
        ph_d = LOWA_LD;
      end
      SQ_LOW_A: if (ph_last) begin
        st_d = SQ_LOW_B;
        ph_d = LOWB_LD;
      end
      SQ_LOW_B: if (ph_last) begin
        st_d = SQ_PRE;
        ph_d = PRE_LD;
      end
      SQ_PRE: if (ph_last) begin
        st_d = SQ_IDLE;
        done = 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase

    row_d = (done && mode_q) ? row_q + 1'b1 : row_q;

    // strobe levels decoded from the coming state, registered below
    ras_n_d   = !(st_d == SQ_LOW_A || st_d == SQ_LOW_B);
    cas_n_d   = !(!mode_d && (st_d == SQ_LEAD || st_d == SQ_LOW_A));
    addr_en_d = mode_d && (st_d == SQ_LEAD || st_d == SQ_LOW_A || st_d == SQ_LOW_B);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      ph_q      <= '0;
      mode_q    <= 1'b0;
      row_q     <= '0;
      ras_n_q   <= 1'b1;
      cas_n_q   <= 1'b1;
      addr_en_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      ph_q      <= ph_d;
      mode_q    <= mode_d;
      row_q     <= row_d;
      ras_n_q   <= ras_n_d;
      cas_n_q   <= cas_n_d;
      addr_en_q <= addr_en_d;
    end
  end

  assign ras_n   = ras_n_q;
  assign cas_n   = cas_n_q;
  assign we_n    = 1'b1;
  assign addr_en = addr_en_q;
  assign idle    = (st_q == SQ_IDLE);
  assign row     = row_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 10000,
  parameter int INTERVAL_CYC = 780,
  parameter int WARMUP_CNT   = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_LOW_CYC  = 3,
  parameter int PRE_CYC      = 2,
  parameter int ROW_W        = 12,
  parameter int PEND_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ras_only,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             init_done,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             addr_en,
  output logic [ROW_W-1:0] row_addr
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int WARM_W  = $clog2(WARMUP_CNT + 1);
  localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CYC - 1);
  localparam logic [WARM_W-1:0]  WARM_ALL   = WARM_W'(WARMUP_CNT);

  init_phase_e        phase_q, phase_d;
  logic [PAUSE_W-1:0] pause_q, pause_d;
  logic [WARM_W-1:0]  warm_q, warm_d;

  logic run, tick, owed_any, seq_idle, seq_done;
  logic start_warm, start_run, start;

  assign run        = (phase_q == PH_RUN);
  assign start_warm = (phase_q == PH_WARM) && seq_idle && (warm_q != WARM_ALL);
  assign start_run  = run && seq_idle && owed_any && bus_gnt;
  assign start      = start_warm || start_run;

  // init phase next-state
  always_comb begin
    phase_d = phase_q;
    pause_d = pause_q;
    warm_d  = warm_q;
    unique case (phase_q)
      PH_PAUSE: begin
        pause_d = pause_q + 1'b1;
        if (pause_q == PAUSE_LAST) phase_d = PH_WARM;
      end
      PH_WARM: begin
        if (start_warm) warm_d = warm_q + 1'b1;
        if (warm_q == WARM_ALL && seq_idle) phase_d = PH_RUN;
      end
      default: phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      pause_q <= '0;
      warm_q  <= '0;
    end else begin
      phase_q <= phase_d;
      pause_q <= pause_d;
      warm_q  <= warm_d;
    end
  end

  rfsh_interval_timer #(
    .INTERVAL_CYC(INTERVAL_CYC)
  ) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run),
    .tick (tick)
  );

  rfsh_owed_ctr #(
    .PEND_W(PEND_W)
  ) owed_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (tick),
    .dec     (start_run),
    .owed_any(owed_any)
  );

  rfsh_cycle_seq #(
    .CSR_CYC    (CSR_CYC),
    .CHR_CYC    (CHR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRE_CYC    (PRE_CYC),
    .ROW_W      (ROW_W)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ras_only(mode_ras_only),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .addr_en (addr_en),
    .idle    (seq_idle),
    .done    (seq_done),
    .row     (row_addr)
  );

  assign bus_req   = run ? (owed_any || !seq_idle) : 1'b1;
  assign init_done = run;

  logic unused_done;
  assign unused_done = seq_done;

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int RAS_LOW_CYC = 3,
  parameter int PRE_CYC     = 2
) (
  input logic clk,
  input logic rst_n,
  input logic bus_gnt,
  input logic bus_req,
  input logic init_done,
  input logic ras_n,
  input logic cas_n,
  input logic addr_en
);

  localparam int SAT = RAS_LOW_CYC + PRE_CYC + 2;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ras_n ? '0 : ((lo_cnt == SAT_V) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ras_n ? '0 : ((hi_cnt == SAT_V) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  assert_cas_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0));

  assert_addr_only_rasonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> cas_n);

  assert_ras_low_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= CW'(RAS_LOW_CYC)));

  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= CW'(PRE_CYC)));

  assert_no_cas_fall_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);

  assert_rasonly_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |-> addr_en);

  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_gnt_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !ras_n) |-> bus_gnt);

  assert_quiet_without_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !bus_req) |-> (ras_n && cas_n));

endmodule

bind dram_refresh_sched rfsh_sched_chk #(
  .RAS_LOW_CYC(RAS_LOW_CYC),
  .PRE_CYC    (PRE_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_gnt  (bus_gnt),
  .bus_req  (bus_req),
  .init_done(init_done),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .addr_en  (addr_en)
);

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;

  localparam int PAUSE = 60;
  localparam int INTV  = 100;
  localparam int WARM  = 8;
  localparam int CSR   = 1;
  localparam int CHR   = 1;
  localparam int RASL  = 3;
  localparam int PRE   = 2;
  localparam int ROWW  = 4;
  localparam int PENDW = 3;
  localparam int CYCL  = CSR + RASL + PRE + 1;
  localparam int NVEC  = 7;
  // {mode_ras_only, intervals withheld, expected burst length}
  localparam int VEC [NVEC][3] = '{
    '{0, 1, 1}, '{0, 3, 3}, '{1, 2, 2}, '{1, 9, 7},
    '{0, 8, 7}, '{1, 1, 1}, '{1, 7, 7}
  };

  logic clk, rst_n, mode_sel, bus_gnt;
  logic bus_req, init_done, ras_n, cas_n, we_n, addr_en;
  logic [ROWW-1:0] row_addr;

  int checks, errors, n_fall;
  int hi_len, lo_len, cas_lo, both_lo, exp_row;
  logic prev_ras, prev_cas;
  bit finished;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .WARMUP_CNT(WARM),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_LOW_CYC(RASL), .PRE_CYC(PRE),
    .ROW_W(ROWW), .PEND_W(PENDW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode_sel), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr_en(addr_en), .row_addr(row_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe timing monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      hi_len = 100; lo_len = 0; cas_lo = 0; both_lo = 0; exp_row = 0;
      prev_ras = 1'b1; prev_cas = 1'b1;
    end else begin
      if (!cas_n) cas_lo++; else cas_lo = 0;
      if (prev_ras && !ras_n) begin
        n_fall++;
        chk(hi_len >= PRE, "R6 precharge before RAS fall", hi_len, PRE);
        chk(we_n == 1'b1, "R5 W high at RAS fall", int'(we_n), 1);
        if (!mode_sel) begin
          chk(cas_lo == CSR + 1, "R4 CAS lead before RAS", cas_lo, CSR + 1);
          chk(addr_en == 1'b0, "R4 address unused in CBR", int'(addr_en), 0);
        end else begin
          chk(cas_n == 1'b1, "R7 CAS high in RAS-only", int'(cas_n), 1);
          chk(addr_en == 1'b1, "R7 address driven", int'(addr_en), 1);
          chk(int'(row_addr) == exp_row, "R8 row number", int'(row_addr), exp_row);
        end
        lo_len = 1;
        both_lo = cas_n ? 0 : 1;
      end else if (!ras_n) begin
        lo_len++;
        if (!cas_n) both_lo++;
      end
      if (!prev_ras && ras_n) begin
        chk(lo_len == RASL, "R6 RAS low width", lo_len, RASL);
        if (mode_sel) exp_row = (exp_row + 1) % (1 << ROWW);
        hi_len = 1;
      end else if (ras_n) begin
        hi_len++;
      end
      if (!prev_cas && cas_n && !ras_n)
        chk(both_lo == CHR, "R4 CAS hold after RAS fall", both_lo, CHR);
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0, cyc, nb;
    checks = 0; errors = 0; n_fall = 0; finished = 0;
    rst_n = 1'b0; bus_gnt = 1'b0; mode_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", int'({ras_n, cas_n, we_n}), 7);
    chk(we_n == 1'b1, "R5 W high in reset", int'(we_n), 1);
    chk(bus_req == 1'b1, "R1 request held in reset", int'(bus_req), 1);
    chk(init_done == 1'b0, "R1 not ready in reset", int'(init_done), 0);
    chk(row_addr == '0, "R8 row zero after reset", int'(row_addr), 0);
    rst_n = 1'b1;

    repeat (PAUSE) @(negedge clk);
    chk(n_fall == 0 && cas_n && ras_n, "R1 quiet during pause", n_fall, 0);
    chk(init_done == 1'b0 && bus_req == 1'b1, "R1 held off during pause",
        int'({init_done, bus_req}), 1);

    while (!init_done) @(negedge clk);
    chk(n_fall == WARM, "R2 warm-up cycle count", n_fall, WARM);
    chk(row_addr == '0, "R8 CBR leaves row unchanged", int'(row_addr), 0);
    chk(bus_req == 1'b0, "R3 no request when nothing owed", int'(bus_req), 0);

    repeat (INTV - 1) @(negedge clk);
    chk(bus_req == 1'b0, "R3 no request before interval", int'(bus_req), 0);
    @(negedge clk);
    chk(bus_req == 1'b1, "R3 request after interval", int'(bus_req), 1);
    f0 = n_fall;
    bus_gnt = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (bus_req);
    bus_gnt = 1'b0;
    chk(n_fall - f0 == 1, "R3 one refresh per interval", n_fall - f0, 1);
    chk(cyc == CYCL, "R9 request release timing", cyc, CYCL);

    for (int v = 0; v < NVEC; v++) begin
      mode_sel = VEC[v][0][0];
      nb = VEC[v][2];
      while (!bus_req) @(negedge clk);
      f0 = n_fall;
      repeat ((VEC[v][1] - 1) * INTV) @(negedge clk);
      chk(n_fall == f0, "R10 no refresh without grant", n_fall - f0, 0);
      bus_gnt = 1'b1;
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (bus_req);
      bus_gnt = 1'b0;
      chk(n_fall - f0 == nb, "R9 owed burst length", n_fall - f0, nb);
      chk(cyc == nb * CYCL, "R9 back-to-back burst duration", cyc, nb * CYCL);
      chk(ras_n && cas_n, "R10 strobes idle after release", int'({ras_n, cas_n}), 3);
    end
    chk(int'(row_addr) == 17 % (1 << ROWW), "R8 row wraps", int'(row_addr), 17 % (1 << ROWW));

    // reset in the middle of a refresh cycle
    mode_sel = 1'b1;
    while (!bus_req) @(negedge clk);
    bus_gnt = 1'b1;
    while (ras_n) @(negedge clk);
    rst_n = 1'b0;
    bus_gnt = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n && !addr_en, "R1 strobes released by reset",
        int'({ras_n, cas_n, addr_en}), 6);
    chk(init_done == 1'b0 && bus_req == 1'b1, "R1 ready cleared by reset",
        int'({init_done, bus_req}), 1);
    chk(row_addr == '0, "R8 row cleared by reset", int'(row_addr), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule